// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking an in-memory translation tree. The tree starts at a context table whose base comes from a root pointer input and whose slot is picked by a context number. Below it there are up to three levels of tables. The walker fetches one 32-bit descriptor at a time over a valid/ready read/write port and waits for each response before it sends the next request.

The walk ends at the first leaf entry it finds. A leaf in the first table maps a 16 MB region, a leaf in the second table maps 256 KB, and a leaf in the third table maps 4 KB. The walker then reports the leaf, a page-size code and the physical address. If the walk cannot finish, it reports a fault code that records the level of the failing fetch and the kind of failure. When the leaf's referenced bit is clear, or when a write finds the modified bit clear, the walker writes the leaf back to the address it came from with those bits set before it reports completion.

A caller applies a one-cycle `start` along with the address, the write flag, the root pointer and the context number. It then waits for the one-cycle `done` pulse. Checking the permissions and caching the results are left to the logic around this block.

Top module: `ptw_walker`

## Requirements
- R1: The first request of a walk is a read at address (ctx_root × 16) + (ctx_num × 4).
- R2: Descriptor bits [1:0] give the entry type: 0 invalid, 1 table pointer, 2 leaf, 3 reserved. A table pointer `d` at context level 0, 1 or 2 makes the next read go to ((d with bits [1:0] cleared) × 16) + 4 × index. The index is va[31:24] for table 1, va[23:18] for table 2 and va[17:12] for table 3.
- R3: A leaf found in table 1, 2 or 3 ends the walk with `fault`=0 and `page_size` = 2 (16 MB), 1 (256 KB) or 0 (4 KB).
- R4: `paddr` = leaf[31:8] × 4096 plus an offset. The offset is va[23:12] × 4096 for a 16 MB leaf, va[17:12] × 4096 for a 256 KB leaf, and zero for a 4 KB leaf.
- R5: An invalid entry ends the walk with `fault`=1 and `fault_code` = level × 256 + 1 × 4. The level is 0 for the context fetch and 1 to 3 for the three tables. On any fault, `pte`, `page_size` and `paddr` read zero.
- R6: These cases end the walk with `fault_code` = level × 256 + 4 × 4: a reserved entry, a read returning `mem_rsp_err`, a leaf in the context slot, or a table pointer in table 3.
- R7: A leaf whose referenced bit (bit 5) is clear, or a write access finding its modified bit (bit 6) clear, is written back to its own address. The written value has bit 5 set, and bit 6 also set for a write. `pte` then shows the written value.
- R8: A leaf that needs no update produces no write, and `pte` shows the leaf exactly as it was read.
- R9: `done` is high for exactly one cycle. `busy` is high from the cycle after an accepted `start` through the `done` cycle. A `start` while `busy` does not change the walk or its requests.
- R10: A request stays asserted, with address, write flag and data unchanged, until `mem_req_ready`. No new request is made while a response is outstanding.
- R11: After reset, `busy`, `done` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| ctx_root | input | 32 | Context table pointer, byte address / 16 |
| ctx_num | input | CTX_W | Context number |
| vaddr | input | 32 | Virtual address to translate |
| is_write | input | 1 | Access is a write |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a fault |
| fault_code | output | 10 | Level in [9:8], fault type in [4:2] |
| pte | output | 32 | Leaf entry as it stands after the walk |
| page_size | output | 2 | 0 = 4 KB, 1 = 256 KB, 2 = 16 MB |
| paddr | output | 36 | Translated physical byte address |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | Request is a write |
| mem_req_addr | output | 36 | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Response valid |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read ended in a bus error |

## Verification
Complete walks go to leaves at all three depths. The 16 MB and 256 KB cases exercise the two large-page offset formulas, and the 4 KB case is repeated with read and write accesses over a single leaf. That sequence shows the referenced-only update, the modified update and the quiet re-access each in turn. Fault walks stop at every level, with invalid and reserved entries and bus errors. These tell apart the fault type and the level that reached the code. A stalled-ready, long-latency run checks that the handshake is held correctly, and a start pulse in mid-walk checks that the active translation is left intact.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int DESC_W  = 32;
  localparam int PA_W    = 36;
  localparam int FC_W    = 10;
  localparam int BIT_REF = 5;
  localparam int BIT_MOD = 6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTX, ST_L1, ST_L2, ST_L3, ST_WB, ST_DONE
  } walk_state_e;

  typedef enum logic [1:0] {
    ACT_DESCEND = 2'd0,
    ACT_LEAF    = 2'd1,
    ACT_FAULT   = 2'd2
  } desc_act_e;

  localparam logic [1:0] ET_INVALID = 2'd0;
  localparam logic [1:0] ET_TABLE   = 2'd1;
  localparam logic [1:0] ET_LEAF    = 2'd2;
  localparam logic [1:0] ET_RSVD    = 2'd3;

  localparam logic [2:0] FT_INVALID = 3'd1;
  localparam logic [2:0] FT_TRANSL  = 3'd4;

  localparam logic [1:0] SZ_4K   = 2'd0;
  localparam logic [1:0] SZ_256K = 2'd1;
  localparam logic [1:0] SZ_16M  = 2'd2;

  function automatic logic [PA_W-1:0] ctx_slot_addr(input logic [31:0] root,
                                                    input logic [31:0] ctx);
    return {root, 4'b0} + {2'b0, ctx, 2'b0};
  endfunction

  function automatic logic [PA_W-1:0] table_base(input logic [DESC_W-1:0] d);
    return {d[31:2], 6'b0};
  endfunction

  function automatic logic [PA_W-1:0] level_index(input logic [1:0] lvl,
                                                  input logic [31:0] va);
    case (lvl)
      2'd1:    return {26'b0, va[31:24], 2'b0};
      2'd2:    return {28'b0, va[23:18], 2'b0};
      2'd3:    return {28'b0, va[17:12], 2'b0};
      default: return '0;
    endcase
  endfunction

  function automatic logic [1:0] leaf_size(input logic [1:0] lvl);
    case (lvl)
      2'd1:    return SZ_16M;
      2'd2:    return SZ_256K;
      default: return SZ_4K;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] phys_addr(input logic [DESC_W-1:0] pte,
                                                input logic [1:0] size,
                                                input logic [31:0] va);
    logic [PA_W-1:0] off;
    case (size)
      SZ_16M:  off = {12'b0, va[23:12], 12'b0};
      SZ_256K: off = {18'b0, va[17:12], 12'b0};
      default: off = '0;
    endcase
    return {pte[31:8], 12'b0} + off;
  endfunction

  function automatic logic [FC_W-1:0] fault_word(input logic [1:0] lvl,
                                                 input logic [2:0] ft);
    return {lvl, 3'b0, ft, 2'b0};
  endfunction

  function automatic logic needs_update(input logic [DESC_W-1:0] pte,
                                        input logic wr);
    return !pte[BIT_REF] || (wr && !pte[BIT_MOD]);
  endfunction

  function automatic logic [DESC_W-1:0] updated_pte(input logic [DESC_W-1:0] pte,
                                                    input logic wr);
    logic [DESC_W-1:0] v;
    v = pte;
    v[BIT_REF] = 1'b1;
    if (wr) v[BIT_MOD] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/ptw_desc_eval.sv
module ptw_desc_eval
  import ptw_pkg::*;
(
  input  logic [1:0] level,
  input  logic [1:0] etype,
  input  logic       bus_err,
  output desc_act_e  act,
  output logic [2:0] ft
);
  always_comb begin
    act = ACT_FAULT;
    ft  = FT_TRANSL;
    if (!bus_err) begin
      case (etype)
        ET_INVALID: ft = FT_INVALID;
        ET_TABLE:   if (level != 2'd3) act = ACT_DESCEND;
        ET_LEAF:    if (level != 2'd0) act = ACT_LEAF;
        default:    ft = FT_TRANSL;
      endcase
    end
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [1:0]        next_level,
  input  logic [DESC_W-1:0] desc,
  input  logic [31:0]       va,
  output logic [PA_W-1:0]   addr
);
  always_comb addr = table_base(desc) + level_index(next_level, va);
endmodule

// File: rtl/ptw_leaf_fmt.sv
module ptw_leaf_fmt
  import ptw_pkg::*;
(
  input  logic [1:0]        level,
  input  logic [DESC_W-1:0] pte_in,
  input  logic [31:0]       va,
  input  logic              wr,
  output logic [1:0]        size,
  output logic [PA_W-1:0]   pa,
  output logic              wb_req,
  output logic [DESC_W-1:0] pte_upd
);
  always_comb begin
    size    = leaf_size(level);
    pa      = phys_addr(pte_in, size, va);
    wb_req  = needs_update(pte_in, wr);
    pte_upd = updated_pte(pte_in, wr);
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int CTX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       ctx_root,
  input  logic [CTX_W-1:0]  ctx_num,
  input  logic [31:0]       vaddr,
  input  logic              is_write,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [FC_W-1:0]   fault_code,
  output logic [DESC_W-1:0] pte,
  output logic [1:0]        page_size,
  output logic [PA_W-1:0]   paddr,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [PA_W-1:0]   mem_req_addr,
  output logic [DESC_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err
);
  localparam int CTX_PAD = 32 - CTX_W;

  walk_state_e       state_q;
  logic [31:0]       va_q;
  logic              wr_q;
  logic [PA_W-1:0]   fetch_addr_q;
  logic              issued_q;
  logic              res_fault_q;
  logic [FC_W-1:0]   res_code_q;
  logic [DESC_W-1:0] res_pte_q;
  logic [1:0]        res_size_q;
  logic [PA_W-1:0]   res_pa_q;

  logic [1:0]        cur_level;
  logic              fetching;
  logic              in_wb;
  logic              req_fire;
  logic              awaiting_rsp;
  logic              rsp_take;
  logic              walk_step;
  desc_act_e         act;
  logic [2:0]        ft;
  logic [PA_W-1:0]   next_addr;
  logic [1:0]        lf_size;
  logic [PA_W-1:0]   lf_pa;
  logic              lf_wb;
  logic [DESC_W-1:0] lf_upd;
  logic [31:0]       ctx_ext;

  always_comb begin
    case (state_q)
      ST_L1:   cur_level = 2'd1;
      ST_L2:   cur_level = 2'd2;
      ST_L3:   cur_level = 2'd3;
      default: cur_level = 2'd0;
    endcase
  end

  assign ctx_ext      = {{CTX_PAD{1'b0}}, ctx_num};
  assign fetching     = (state_q == ST_CTX) || (state_q == ST_L1) ||
                        (state_q == ST_L2)  || (state_q == ST_L3);
  assign in_wb        = (state_q == ST_WB);
  assign mem_req_valid = (fetching || in_wb) && !issued_q;
  assign mem_req_we    = in_wb;
  assign mem_req_addr  = fetch_addr_q;
  assign mem_req_wdata = in_wb ? res_pte_q : '0;
  assign req_fire     = mem_req_valid && mem_req_ready;
  assign awaiting_rsp = issued_q;
  assign rsp_take     = issued_q && mem_rsp_valid;
  assign walk_step    = rsp_take && fetching;

  ptw_desc_eval u_eval (
    .level  (cur_level),
    .etype  (mem_rsp_data[1:0]),
    .bus_err(mem_rsp_err),
    .act    (act),
    .ft     (ft)
  );

  ptw_addr_gen u_addr (
    .next_level(cur_level + 2'd1),
    .desc      (mem_rsp_data),
    .va        (va_q),
    .addr      (next_addr)
  );

  ptw_leaf_fmt u_leaf (
    .level  (cur_level),
    .pte_in (mem_rsp_data),
    .va     (va_q),
    .wr     (wr_q),
    .size   (lf_size),
    .pa     (lf_pa),
    .wb_req (lf_wb),
    .pte_upd(lf_upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      va_q         <= '0;
      wr_q         <= 1'b0;
      fetch_addr_q <= '0;
      issued_q     <= 1'b0;
      res_fault_q  <= 1'b0;
      res_code_q   <= '0;
      res_pte_q    <= '0;
      res_size_q   <= '0;
      res_pa_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            va_q         <= vaddr;
            wr_q         <= is_write;
            fetch_addr_q <= ctx_slot_addr(ctx_root, ctx_ext);
            issued_q     <= 1'b0;
            state_q      <= ST_CTX;
          end
        end
        ST_CTX, ST_L1, ST_L2, ST_L3: begin
          if (req_fire) issued_q <= 1'b1;
          if (walk_step) begin
            issued_q <= 1'b0;
            case (act)
              ACT_DESCEND: begin
                fetch_addr_q <= next_addr;
                case (state_q)
                  ST_CTX:  state_q <= ST_L1;
                  ST_L1:   state_q <= ST_L2;
                  default: state_q <= ST_L3;
                endcase
              end
              ACT_LEAF: begin
                res_fault_q <= 1'b0;
                res_code_q  <= '0;
                res_size_q  <= lf_size;
                res_pa_q    <= lf_pa;
                res_pte_q   <= lf_wb ? lf_upd : mem_rsp_data;
                state_q     <= lf_wb ? ST_WB : ST_DONE;
              end
              default: begin
                res_fault_q <= 1'b1;
                res_code_q  <= fault_word(cur_level, ft);
                res_size_q  <= '0;
                res_pa_q    <= '0;
                res_pte_q   <= '0;
                state_q     <= ST_DONE;
              end
            endcase
          end
        end
        ST_WB: begin
          if (req_fire) issued_q <= 1'b1;
          if (rsp_take) begin
            issued_q <= 1'b0;
            state_q  <= ST_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign fault      = res_fault_q;
  assign fault_code = res_code_q;
  assign pte        = res_pte_q;
  assign page_size  = res_size_q;
  assign paddr      = res_pa_q;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [FC_W-1:0]   fault_code,
  input logic [1:0]        page_size,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [PA_W-1:0]   mem_req_addr,
  input logic [DESC_W-1:0] mem_req_wdata,
  input logic              awaiting_rsp
);
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !done));

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) &&
       $stable(mem_req_wdata)));

  assert_one_outstanding_R10: assert property (@(posedge clk) disable iff (!rst_n)
    awaiting_rsp |-> !mem_req_valid);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  assert_busy_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  assert_fault_kind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |->
      ((fault_code[4:2] == FT_INVALID || fault_code[4:2] == FT_TRANSL) &&
       fault_code[7:5] == 3'b0 && fault_code[1:0] == 2'b0));

  assert_leaf_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (page_size != 2'd3));

  assert_wb_ref_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> mem_req_wdata[BIT_REF]);
endmodule

bind ptw_walker ptw_walker_chk u_ptw_walker_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .done         (done),
  .fault        (fault),
  .fault_code   (fault_code),
  .page_size    (page_size),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_we   (mem_req_we),
  .mem_req_addr (mem_req_addr),
  .mem_req_wdata(mem_req_wdata),
  .awaiting_rsp (awaiting_rsp)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctx_root = '0;
  logic [7:0]  ctx_num = '0;
  logic [31:0] vaddr = '0;
  logic        is_write = 1'b0;
  logic        busy, done, fault;
  logic [9:0]  fault_code;
  logic [31:0] pte;
  logic [1:0]  page_size;
  logic [35:0] paddr;
  logic        mem_req_valid, mem_req_we;
  logic        mem_req_ready = 1'b1;
  logic [35:0] mem_req_addr;
  logic [31:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        mem_rsp_err = 1'b0;

  always #2 clk = ~clk;

  ptw_walker i_ptw_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .ctx_root(ctx_root),
    .ctx_num(ctx_num), .vaddr(vaddr), .is_write(is_write), .busy(busy),
    .done(done), .fault(fault), .fault_code(fault_code), .pte(pte),
    .page_size(page_size), .paddr(paddr), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .mem_rsp_err(mem_rsp_err)
  );

  int errors = 0;
  int checks = 0;

  // sparse memory and bus-error map
  logic [31:0] mem [longint];
  bit          err_at [longint];

  // expected request stream, filled by the reference model
  bit          exp_we [$];
  longint      exp_addr [$];
  logic [31:0] exp_wdata [$];
  string       exp_tag [$];

  // expected walk result
  bit          e_fault;
  longint      e_code, e_pte, e_size, e_pa;
  string       e_tag;

  bit stall_mode = 1'b0;
  int lat_cfg = 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic longint idx_of(input int lvl, input longint va);
    if (lvl == 1) return (va >> 24) % 256;
    if (lvl == 2) return (va >> 18) % 64;
    return (va >> 12) % 64;
  endfunction

  function automatic longint slot(input longint base, input int lvl, input longint va);
    return base + 4 * idx_of(lvl, va);
  endfunction

  function automatic logic [31:0] pdesc(input longint base);
    return 32'((base / 16) + 1);
  endfunction

  // behavioural reference of a complete walk
  task automatic model_walk(input longint root, input int ctxn,
                            input longint va, input bit wr);
    longint a;
    longint d;
    longint et;
    a = root * 16 + ctxn * 4;
    e_fault = 1'b0; e_code = 0; e_pte = 0; e_size = 0; e_pa = 0;
    for (int lvl = 0; lvl < 4; lvl++) begin
      exp_we.push_back(1'b0); exp_addr.push_back(a);
      exp_wdata.push_back('0); exp_tag.push_back(lvl == 0 ? "R1" : "R2");
      d = mem.exists(a) ? longint'(mem[a]) : 0;
      et = d % 4;
      if (err_at.exists(a) || et == 3 || (et == 2 && lvl == 0) ||
          (et == 1 && lvl == 3)) begin
        e_fault = 1'b1; e_code = lvl * 256 + 16; e_tag = "R6"; break;
      end
      if (et == 0) begin
        e_fault = 1'b1; e_code = lvl * 256 + 4; e_tag = "R5"; break;
      end
      if (et == 1) begin
        a = (d / 4) * 64 + 4 * idx_of(lvl + 1, va);
        continue;
      end
      // leaf
      e_tag = "R3";
      if (lvl == 1) begin e_size = 2; e_pa = ((va >> 12) % 4096) * 4096; end
      else if (lvl == 2) begin e_size = 1; e_pa = ((va >> 12) % 64) * 4096; end
      else begin e_size = 0; e_pa = 0; end
      e_pa = e_pa + (d / 256) * 4096;
      if (((d / 32) % 2) == 0 || (wr && ((d / 64) % 2) == 0)) begin
        e_pte = d | 32 | (wr ? 64 : 0);
        e_tag = "R7";
        exp_we.push_back(1'b1); exp_addr.push_back(a);
        exp_wdata.push_back(32'(e_pte)); exp_tag.push_back("R7");
      end else begin
        e_pte = d;
        if (wr || ((d / 32) % 2) == 1) e_tag = "R8";
      end
      break;
    end
  endtask

  // memory responder: compares every accepted request with the model
  initial begin
    int cyc = 0;
    int lat_left = 0;
    logic [31:0] pend_data = '0;
    bit pend_err = 1'b0;
    longint a;
    string tg;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      mem_rsp_err = 1'b0;
      mem_req_ready = stall_mode ? ((cyc % 3) == 2) : 1'b1;
      if (lat_left > 0) begin
        lat_left--;
        if (lat_left == 0) begin
          mem_rsp_valid = 1'b1; mem_rsp_data = pend_data; mem_rsp_err = pend_err;
        end
      end else if (mem_req_valid && mem_req_ready) begin
        a = longint'(mem_req_addr);
        if (exp_addr.size() == 0) begin
          chk(1'b0, "R10", "unexpected request addr", a, 0);
        end else begin
          tg = stall_mode ? "R10" : exp_tag[0];
          chk(mem_req_we == exp_we[0], tg, "request write flag",
              longint'(mem_req_we), longint'(exp_we[0]));
          chk(a == exp_addr[0], tg, "request address", a, exp_addr[0]);
          if (exp_we[0])
            chk(mem_req_wdata == exp_wdata[0], tg, "write data",
                longint'(mem_req_wdata), longint'(exp_wdata[0]));
          void'(exp_we.pop_front()); void'(exp_addr.pop_front());
          void'(exp_wdata.pop_front()); void'(exp_tag.pop_front());
        end
        if (mem_req_we) begin
          mem[a] = mem_req_wdata; pend_data = '0; pend_err = 1'b0;
        end else begin
          pend_data = mem.exists(a) ? mem[a] : '0;
          pend_err = err_at.exists(a);
        end
        lat_left = lat_cfg;
      end
    end
  end

  task automatic run_walk(input longint root, input int ctxn, input longint va,
                          input bit wr, input bit poke);
    int waited = 0;
    model_walk(root, ctxn, va, wr);
    @(negedge clk);
    ctx_root = 32'(root); ctx_num = 8'(ctxn); vaddr = 32'(va); is_write = wr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    vaddr = 32'hFFFF_F000; is_write = ~wr; ctx_num = 8'hEE;
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b1, "R9", "busy mid-walk", longint'(busy), 1);
      start = 1'b1; vaddr = 32'h7700_0000;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done && waited < 500) begin
      @(negedge clk);
      waited++;
    end
    if (!done) begin
      chk(1'b0, "R9", "walk timed out", 0, 1);
    end else begin
      chk(fault == e_fault, e_tag, "fault flag", longint'(fault), longint'(e_fault));
      chk(longint'(fault_code) == e_code, e_tag, "fault code", longint'(fault_code), e_code);
      chk(longint'(pte) == e_pte, e_tag, "pte", longint'(pte), e_pte);
      chk(longint'(page_size) == e_size, e_tag == "R7" || e_tag == "R8" ? "R3" : e_tag,
          "page size", longint'(page_size), e_size);
      chk(longint'(paddr) == e_pa, e_fault ? e_tag : "R4", "paddr", longint'(paddr), e_pa);
      chk(exp_addr.size() == 0, poke ? "R9" : "R8", "requests left over",
          longint'(exp_addr.size()), 0);
      @(negedge clk);
      chk(!done && !busy, "R9", "done one cycle, idle after", longint'({done, busy}), 0);
    end
  endtask

  localparam longint ROOT = 64'h1000;
  localparam longint CTXT = 64'h10000;
  localparam longint L1T = 64'h20000, L2T = 64'h30000, L3T = 64'h40000;
  localparam longint L2B = 64'h50000;

  initial begin
    mem[CTXT + 3 * 4] = pdesc(L1T);
    mem[CTXT + 6 * 4] = 32'h0000_0002;
    mem[CTXT + 7 * 4] = pdesc(L1T);
    err_at[CTXT + 7 * 4] = 1'b1;
    mem[slot(L1T, 1, 64'h12345678)] = pdesc(L2T);
    mem[slot(L2T, 2, 64'h12345678)] = pdesc(L3T);
    mem[slot(L3T, 3, 64'h12345678)] = 32'h0ABC_DE0E;
    mem[slot(L1T, 1, 64'h5A7C3123)] = 32'h00F0_002A;
    mem[slot(L2T, 2, 64'h12F6B9AB)] = 32'h1234_5662;
    mem[slot(L2T, 2, 64'h12000000)] = 32'h0000_0003;
    mem[slot(L3T, 3, 64'h12346000)] = pdesc(64'h70000);
    mem[slot(L1T, 1, 64'h33000000)] = pdesc(L2B);
    err_at[slot(L2B, 2, 64'h33000000)] = 1'b1;
    mem[slot(L1T, 1, 64'h44000000)] = 32'h0000_0003;
    mem[slot(L3T, 3, 64'h1234A000)] = 32'h0012_3002;

    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_req_valid, "R11", "reset outputs",
        longint'({busy, done, mem_req_valid}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_req_valid, "R11", "idle after reset",
        longint'({busy, mem_req_valid}), 0);

    run_walk(ROOT, 3, 64'h12345678, 1'b0, 1'b0); // R7 referenced update
    run_walk(ROOT, 3, 64'h12345678, 1'b0, 1'b0); // R8 no update
    run_walk(ROOT, 3, 64'h12345678, 1'b1, 1'b0); // R7 modified update
    run_walk(ROOT, 3, 64'h12345678, 1'b1, 1'b0); // R8 no update
    run_walk(ROOT, 3, 64'h5A7C3123, 1'b0, 1'b0); // R3 R4 16 MB
    run_walk(ROOT, 3, 64'h12F6B9AB, 1'b1, 1'b0); // R3 R4 256 KB
    run_walk(ROOT, 5, 64'h12345678, 1'b0, 1'b0); // R5 level 0
    run_walk(ROOT, 6, 64'h12345678, 1'b0, 1'b0); // R6 leaf in context slot
    run_walk(ROOT, 7, 64'h12345678, 1'b0, 1'b0); // R6 bus error level 0
    run_walk(ROOT, 3, 64'h77000000, 1'b0, 1'b0); // R5 level 1
    run_walk(ROOT, 3, 64'h44000000, 1'b0, 1'b0); // R6 reserved level 1
    run_walk(ROOT, 3, 64'h12000000, 1'b0, 1'b0); // R6 reserved level 2
    run_walk(ROOT, 3, 64'h33000000, 1'b0, 1'b0); // R6 bus error level 2
    run_walk(ROOT, 3, 64'h12346000, 1'b0, 1'b0); // R6 pointer at level 3
    run_walk(ROOT, 3, 64'h12347000, 1'b0, 1'b0); // R5 level 3
    stall_mode = 1'b1; lat_cfg = 3;
    run_walk(ROOT, 3, 64'h1234A000, 1'b1, 1'b0); // R10 stalled handshake
    run_walk(ROOT, 3, 64'h5A7C3123, 1'b0, 1'b0); // R10
    stall_mode = 1'b0; lat_cfg = 2;
    run_walk(ROOT, 3, 64'h12345678, 1'b0, 1'b1); // R9 start ignored while busy
    repeat (5) @(negedge clk);
    chk(!busy && !mem_req_valid, "R9", "quiet after ignored start",
        longint'({busy, mem_req_valid}), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R9 watchdog expired: actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule